// File: doc/BRIEF.md
# Presettable Cascadable Decade Counter Digit

This block is one decimal digit of a synchronous counter. On each rising clock edge it steps its 4-bit value through 0 to 9 and then back to 0. It can take a value from four parallel data inputs on a clock edge. A clear input, active low, zeroes the digit at once without waiting for a clock edge. Counting happens only while both of its enable inputs are high.

A carry output goes high when the digit holds 9 and its carry-side enable is high. Wire this output to the carry-side enable of the next more significant digit. A chain of instances then forms a multi-digit decimal counter that advances in lockstep on one clock. The other enable input is shared across the whole chain and starts or stops the entire count.

The value is held in a register. The carry is decoded combinationally from the register and the carry-side enable, so it settles within the same cycle through any number of chained digits. If a value from 10 to 15 is loaded, the next counting edge takes the digit to 0.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 and `carry` is 0. This takes effect as soon as `clr_n` falls, before any clock edge.
- R2: With `clr_n` high, `load` low and both `en_p` and `en_t` high, a rising edge raises `q` by one while `q` is below 9.
- R3: A counting edge taken while `q` is 9 makes `q` 0.
- R4: With `load` high, a rising edge copies `d_in` into `q`, whatever the state of `en_p` and `en_t`.
- R5: A low `clr_n` overrides both `load` and counting: `q` stays 0 through clock edges while it is low.
- R6: With `load` low and either `en_p` or `en_t` low, `q` keeps its value across a rising edge.
- R7: `carry` is 1 exactly when `q` is 9 and `en_t` is 1. It does not depend on `en_p`.
- R8: A counting edge taken while `q` holds a non-decimal code from 10 to 15 makes `q` 0. `carry` stays 0 while such a code is held.
- R9: Two digits chained (low digit `carry` into high digit `en_t`, shared `en_p`) count 00 through 99 and wrap to 00. The high digit advances only on the edge where the low digit goes from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Synchronous parallel load, active high |
| d_in | input | 4 | Value taken on a load edge |
| en_p | input | 1 | Count enable shared across a chain |
| en_t | input | 1 | Count enable that also gates `carry` |
| q | output | 4 | Registered digit value |
| carry | output | 1 | High when `q` is 9 and `en_t` is high |

## Verification
The properties assume that `d_in`, `load` and both enables are stable around each rising edge. They also assume that `clr_n` rises away from an edge, because an edge right at release would leave the first cycle ambiguous. The bench changes every input only on falling edges. It drops `clr_n` mid-cycle and raises it on a falling edge, so no property ever samples a value in transition. Non-decimal codes reach the digit only through `d_in`, and the bench loads codes from 10 to 15 on purpose to cover that path.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  // Action the digit register takes on the next rising edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } digit_op_t;

endpackage

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
  import bcd_pkg::*;
(
  input  logic      load,
  input  logic      en_p,
  input  logic      en_t,
  output digit_op_t op
);

  // Load wins over counting; counting needs both enables.
  always_comb begin
    if (load)              op = OP_LOAD;
    else if (en_p && en_t) op = OP_STEP;
    else                   op = OP_HOLD;
  end

endmodule

// File: rtl/bcd_step.sv
module bcd_step #(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] LastVal = WIDTH'(LAST);
  localparam logic [WIDTH-1:0] One     = WIDTH'(1);

  generate
    if (LAST == (1 << WIDTH) - 1) begin : g_full_range
      // Natural wrap of the adder covers the terminal value.
      assign nxt = cur + One;
    end else begin : g_truncated
      // Terminal value and every unused code lead to zero.
      assign nxt = (cur >= LastVal) ? '0 : cur + One;
    end
  endgenerate

endmodule

// File: rtl/bcd_state.sv
module bcd_state
  import bcd_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  logic             clr_n,
  input  digit_op_t        op,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] LastVal = WIDTH'(LAST);
  localparam logic [WIDTH-1:0] One     = WIDTH'(1);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD: q <= d_in;
        OP_STEP: q <= nxt;
        default: q <= q;
      endcase
    end
  end

  // R2: counting below the terminal value adds one
  p_step_incr_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_STEP && q < LastVal) |=> (q == $past(q) + One));

  // R3: counting from the terminal value returns to zero
  p_step_wrap_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_STEP && q == LastVal) |=> (q == '0));

  // R4: a load edge captures the data inputs
  p_load_take_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_LOAD) |=> (q == $past(d_in)));

  // R6: without load or both enables the value is kept
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_HOLD) |=> $stable(q));

  // R8: a non-decimal code leaves for zero on a counting edge
  p_recover_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (op == OP_STEP && q > LastVal) |=> (q == '0));

endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int LAST  = 9
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d_in,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  localparam logic [WIDTH-1:0] LastVal = WIDTH'(LAST);

  digit_op_t        op;
  logic [WIDTH-1:0] nxt;

  bcd_ctrl u_ctrl (
    .load (load),
    .en_p (en_p),
    .en_t (en_t),
    .op   (op)
  );

  bcd_step #(.WIDTH(WIDTH), .LAST(LAST)) u_step (
    .cur (q),
    .nxt (nxt)
  );

  bcd_state #(.WIDTH(WIDTH), .LAST(LAST)) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .d_in  (d_in),
    .nxt   (nxt),
    .q     (q)
  );

  // Terminal-count decode, gated by the chain-side enable.
  assign carry = en_t && (q == LastVal);

  // R7: a carry during a counting edge is followed by zero
  p_carry_roll_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (carry && en_p && !load) |=> (q == '0));

  // R7: no carry leaves the digit while its chain enable is low
  p_carry_gate_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_t) |-> (!carry));

  // R8: no carry while a non-decimal code is held
  p_carry_range_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (q > LastVal) |-> (!carry));

endmodule

// File: tb/test_bcd_decade_counter.sv
`timescale 1ns/1ps
module test_bcd_decade_counter;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load = 1'b0;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;
  logic [3:0] d_lo = 4'd0;
  logic [3:0] d_hi = 4'd0;
  logic [3:0] q_lo, q_hi;
  logic       c_lo, c_hi;

  int n_checks = 0;
  int n_fail   = 0;
  int m_lo = 0;
  int m_hi = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_decade_counter i_bcd_decade_counter (
    .clk (clk), .clr_n (clr_n), .load (load), .d_in (d_lo),
    .en_p (en_p), .en_t (en_t), .q (q_lo), .carry (c_lo)
  );

  bcd_decade_counter i_bcd_decade_counter_hi (
    .clk (clk), .clr_n (clr_n), .load (load), .d_in (d_hi),
    .en_p (en_p), .en_t (c_lo), .q (q_hi), .carry (c_hi)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int ecl, ech;
    ecl = (m_lo == 9 && en_t) ? 1 : 0;
    ech = (m_hi == 9 && ecl == 1) ? 1 : 0;
    chk(req, "q_lo", int'(q_lo), m_lo);
    chk(req, "q_hi", int'(q_hi), m_hi);
    chk(req, "carry_lo", int'(c_lo), ecl);
    chk(req, "carry_hi", int'(c_hi), ech);
  endtask

  // One clock: reference model advanced at the edge, outputs checked at the falling edge.
  task automatic cycle(input string req);
    bit cl;
    @(posedge clk);
    cl = (m_lo == 9) && en_t;
    if (!clr_n) begin
      m_lo = 0; m_hi = 0;
    end else if (load) begin
      m_lo = int'(d_lo); m_hi = int'(d_hi);
    end else begin
      if (en_p && cl)   m_hi = (m_hi >= 9) ? 0 : m_hi + 1;
      if (en_p && en_t) m_lo = (m_lo >= 9) ? 0 : m_lo + 1;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R1");
    clr_n = 1'b1;

    // R2, R3, R9: chained count from 00 around to 00
    en_p = 1'b1; en_t = 1'b1;
    for (int i = 0; i < 9; i++) cycle("R2");
    cycle("R3");
    for (int i = 0; i < 95; i++) cycle("R9");
    chk("R9", "wrapped_lo", int'(q_lo), 5);
    chk("R9", "wrapped_hi", int'(q_hi), 0);

    // R6: both enables low, then en_p low alone
    en_p = 1'b0; en_t = 1'b0;
    for (int i = 0; i < 3; i++) cycle("R6");
    en_t = 1'b1;
    for (int i = 0; i < 3; i++) cycle("R6");

    // R4: load with enables low, then with enables high
    load = 1'b1; d_lo = 4'd7; d_hi = 4'd3;
    en_p = 1'b0; en_t = 1'b0;
    cycle("R4");
    en_p = 1'b1; en_t = 1'b1; d_lo = 4'd9; d_hi = 4'd9;
    cycle("R4");

    // R7: carry with en_p low (no count), and carry gated by en_t
    load = 1'b0; en_p = 1'b0; en_t = 1'b1;
    cycle("R7");
    en_t = 1'b0;
    cycle("R7");
    en_p = 1'b1; en_t = 1'b1;
    cycle("R7");

    // R8: non-decimal codes recover on counting edges
    load = 1'b1; d_lo = 4'd12; d_hi = 4'd15;
    en_p = 1'b0;
    cycle("R8");
    load = 1'b0; en_p = 1'b1;
    for (int i = 0; i < 11; i++) cycle("R8");
    load = 1'b1; d_lo = 4'd10; d_hi = 4'd11;
    cycle("R8");
    load = 1'b0;
    for (int i = 0; i < 3; i++) cycle("R8");

    // R1: asynchronous clear mid-cycle, seen before any edge
    load = 1'b1; d_lo = 4'd6; d_hi = 4'd4;
    cycle("R4");
    load = 1'b0;
    #2;
    clr_n = 1'b0;
    #1;
    chk("R1", "async_q_lo", int'(q_lo), 0);
    chk("R1", "async_q_hi", int'(q_hi), 0);
    chk("R1", "async_carry_lo", int'(c_lo), 0);
    m_lo = 0; m_hi = 0;
    @(negedge clk);

    // R5: clear held over load and count edges
    load = 1'b1; d_lo = 4'd5; d_hi = 4'd8;
    for (int i = 0; i < 2; i++) cycle("R5");
    load = 1'b0;
    cycle("R5");
    clr_n = 1'b1;
    for (int i = 0; i < 4; i++) cycle("R2");

    finish_run();
  end

endmodule